// File: doc/BRIEF.md
# Multiplexer Channel-Select Latch with Readback

This block is the digital control front end of an analog switch multiplexer with 8 (or 4) channels. A small parallel bus carries a channel address and an enable bit. A level-sensitive latch holds them while an active-low write strobe and a direction pin permit it. The same bus pins can turn around and drive the stored selection back out, so a host can confirm which channel is closed. The pins are modelled as separate input, output and output-enable signals.

An active-low asynchronous reset overrides both the strobe and the direction pin. It empties the latch and opens every switch, so it can be held during power-up. The stored selection is decoded into one-hot switch-close outputs.

The control pins are first decoded into one of four named bus modes:
- `MODE_RESET`: reset held.
- `MODE_LOAD`: strobe low, direction low.
- `MODE_READBACK`: strobe high, direction high.
- `MODE_FLOAT`: every other combination.

There is no clock. Each mode follows from the present pin levels, and a change of pins is the only transition between modes. Reset release leads to `MODE_LOAD`, `MODE_READBACK` or `MODE_FLOAT`, according to the pins. A rising strobe moves `MODE_LOAD` to `MODE_FLOAT`. A rising direction pin then moves on to `MODE_READBACK`.

Top module: `mux_select_latch`

## Requirements
- R1: While rst_n=1, wr_n=0 and dir=0, the latch is transparent: a change on bus_i appears on sw_close with no clock.
- R2: While rst_n=1, wr_n=1 and dir=1, bus_oe=1 and bus_o equals the stored selection.
- R3: While rst_n=1, wr_n=1 and dir=0, bus_oe=0, and changes on bus_i do not alter sw_close or the stored value.
- R4: The stored value is the bus_i value present when wr_n last rose while dir=0.
- R5: While rst_n=0, sw_close is all zero and bus_oe=0, whatever wr_n and dir are. After release, readback returns all zero.
- R6: The bus field layout is fixed: bit ADDR_W is the enable, and bits ADDR_W-1:0 are the channel address. With enable 1, exactly the sw_close bit indexed by the address is 1.
- R7: With stored enable 0, sw_close is all zero for every address.
- R8: While rst_n=1, wr_n=0 and dir=1, bus_oe=0 and the latch holds, ignoring bus_i.
- R9: With CHANNELS=4 the bus is 3 bits wide, and R1 to R7 apply with a 2-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear; overrides all other controls |
| wr_n | input | 1 | Active-low write strobe; the latch is open while low |
| dir | input | 1 | Direction: 0 = pins receive, 1 = pins drive back |
| bus_i | input | ADDR_W+1 | Pin input value: {enable, address} |
| bus_o | output | ADDR_W+1 | Pin output value during readback: {enable, address} |
| bus_oe | output | 1 | Pin output enable; 1 only in readback |
| sw_close | output | CHANNELS | One-hot switch-close controls |

## Verification
The bench builds two copies of the block, one with CHANNELS=8 and one with CHANNELS=4. Both are small enough that every bus value can be written, held against an inverted bus, read back and decoded. Every enable/address pair is therefore covered in both widths, including enable-0 words and the top address.

All four control combinations are visited with reset released. Reset is also asserted with the strobe open and with the pins driving, so the override is checked from each mode.

// File: rtl/mux_select_pkg.sv
package mux_select_pkg;

    typedef enum logic [1:0] {
        MODE_RESET    = 2'd0,
        MODE_LOAD     = 2'd1,
        MODE_READBACK = 2'd2,
        MODE_FLOAT    = 2'd3
    } bus_mode_e;

endpackage

// File: rtl/mux_select_mode.sv
module mux_select_mode
    import mux_select_pkg::*;
(
    input  logic      rst_n,
    input  logic      wr_n,
    input  logic      dir,
    output bus_mode_e mode,
    output logic      load,
    output logic      drive
);

    // Pin levels select the mode; reset has priority over everything.
    always_comb begin
        if (!rst_n) begin
            mode = MODE_RESET;
        end else begin
            unique case ({wr_n, dir})
                2'b00:   mode = MODE_LOAD;
                2'b11:   mode = MODE_READBACK;
                default: mode = MODE_FLOAT;
            endcase
        end
    end

    // Outputs of the mode decode.
    always_comb begin
        load  = 1'b0;
        drive = 1'b0;
        unique case (mode)
            MODE_RESET:    ;
            MODE_LOAD:     load  = 1'b1;
            MODE_READBACK: drive = 1'b1;
            MODE_FLOAT:    ;
        endcase
    end

endmodule

// File: rtl/mux_select_store.sv
module mux_select_store #(
    parameter int BUS_W = 4
) (
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] d,
    output logic [BUS_W-1:0] q
);

    // Level-sensitive storage with asynchronous clear.
    always_latch begin
        if (!rst_n) begin
            q = '0;
        end else if (load) begin
            q = d;
        end
    end

endmodule

// File: rtl/mux_select_decode.sv
module mux_select_decode #(
    parameter int CHANNELS = 8,
    parameter int ADDR_W   = $clog2(CHANNELS)
) (
    input  logic                rst_n,
    input  logic [ADDR_W:0]     sel,
    output logic [CHANNELS-1:0] sw_close
);

    logic              sel_en;
    logic [ADDR_W-1:0] sel_addr;

    assign sel_en   = sel[ADDR_W];
    assign sel_addr = sel[ADDR_W-1:0];

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_sw
        assign sw_close[ch] = rst_n && sel_en && (sel_addr == ADDR_W'(ch));
    end

endmodule

// File: rtl/mux_select_latch.sv
module mux_select_latch
    import mux_select_pkg::*;
#(
    parameter int CHANNELS = 8,
    localparam int ADDR_W  = $clog2(CHANNELS),
    localparam int BUS_W   = ADDR_W + 1
) (
    input  logic                rst_n,
    input  logic                wr_n,
    input  logic                dir,
    input  logic [BUS_W-1:0]    bus_i,
    output logic [BUS_W-1:0]    bus_o,
    output logic                bus_oe,
    output logic [CHANNELS-1:0] sw_close
);

    bus_mode_e        mode;
    logic             load;
    logic             drive;
    logic [BUS_W-1:0] held;

    mux_select_mode u_mode (
        .rst_n (rst_n),
        .wr_n  (wr_n),
        .dir   (dir),
        .mode  (mode),
        .load  (load),
        .drive (drive)
    );

    mux_select_store #(.BUS_W(BUS_W)) u_store (
        .rst_n (rst_n),
        .load  (load),
        .d     (bus_i),
        .q     (held)
    );

    mux_select_decode #(.CHANNELS(CHANNELS)) u_dec (
        .rst_n    (rst_n),
        .sel      (held),
        .sw_close (sw_close)
    );

    assign bus_oe = drive;
    assign bus_o  = drive ? held : '0;

endmodule

// File: rtl/mux_select_latch_chk.sv
module mux_select_latch_chk #(
    parameter int CHANNELS = 8,
    localparam int ADDR_W  = $clog2(CHANNELS),
    localparam int BUS_W   = ADDR_W + 1
) (
    input logic                rst_n,
    input logic                wr_n,
    input logic                dir,
    input logic [BUS_W-1:0]    bus_o,
    input logic                bus_oe,
    input logic [BUS_W-1:0]    held,
    input logic [CHANNELS-1:0] sw_close
);

    always_comb begin
        if (!rst_n) begin
            assert_reset_opens_R5: assert (sw_close == '0 && !bus_oe)
                else $error("R5: switch or pin active during reset");
        end
        assert_onehot_R6: assert ($onehot0(sw_close))
            else $error("R6: more than one switch closed");
        if (rst_n && held[ADDR_W]) begin
            assert_addr_selects_R6: assert (sw_close[held[ADDR_W-1:0]])
                else $error("R6: addressed switch not closed");
        end
        if (!held[ADDR_W]) begin
            assert_disabled_open_R7: assert (sw_close == '0)
                else $error("R7: switch closed while disabled");
        end
        if (bus_oe) begin
            assert_oe_readback_R2: assert (rst_n && wr_n && dir && bus_o == held)
                else $error("R2: pins driven outside readback or wrong value");
        end
        if (!wr_n) begin
            assert_no_drive_write_R8: assert (!bus_oe)
                else $error("R8: pins driven with strobe low");
        end
    end

endmodule

bind mux_select_latch mux_select_latch_chk #(.CHANNELS(CHANNELS)) u_chk (
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .dir      (dir),
    .bus_o    (bus_o),
    .bus_oe   (bus_oe),
    .held     (held),
    .sw_close (sw_close)
);

// File: tb/sim_mux_select_latch.sv
module sim_mux_select_latch;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_n  = 1'b1;
    logic       dir   = 1'b0;
    logic [3:0] bus8_i = '0;
    logic [2:0] bus4_i = '0;
    logic [3:0] bus8_o;
    logic [2:0] bus4_o;
    logic       oe8, oe4;
    logic [7:0] sw8;
    logic [3:0] sw4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mux_select_latch #(.CHANNELS(8)) u0 (
        .rst_n(rst_n), .wr_n(wr_n), .dir(dir), .bus_i(bus8_i),
        .bus_o(bus8_o), .bus_oe(oe8), .sw_close(sw8)
    );

    mux_select_latch #(.CHANNELS(4)) u1 (
        .rst_n(rst_n), .wr_n(wr_n), .dir(dir), .bus_i(bus4_i),
        .bus_o(bus4_o), .bus_oe(oe4), .sw_close(sw4)
    );

    function automatic logic [7:0] exp_sw8(input logic [3:0] v);
        return v[3] ? (8'd1 << v[2:0]) : 8'd0;
    endfunction

    function automatic logic [3:0] exp_sw4(input logic [2:0] v);
        return v[2] ? (4'd1 << v[1:0]) : 4'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // Reset state (R5).
        settle();
        check("R5 reset sw8", 32'(sw8), 0);
        check("R5 reset oe8", 32'(oe8), 0);
        check("R5 reset sw4", 32'(sw4), 0);
        rst_n = 1'b1;
        settle();

        // 8-channel sweep: write, hold, readback.
        for (int v = 0; v < 16; v++) begin
            dir = 1'b0; wr_n = 1'b0; bus8_i = 4'(v);
            settle();
            check("R1 transparent", 32'(sw8), 32'(exp_sw8(4'(v))));
            check(v[3] ? "R6 decode" : "R7 disabled", 32'(sw8), 32'(exp_sw8(4'(v))));
            wr_n = 1'b1;
            settle();
            bus8_i = ~4'(v);
            settle();
            check("R3 hold sw", 32'(sw8), 32'(exp_sw8(4'(v))));
            check("R3 float oe", 32'(oe8), 0);
            dir = 1'b1;
            settle();
            check("R2 readback oe", 32'(oe8), 1);
            check("R4 readback value", 32'(bus8_o), 32'(v));
            dir = 1'b0;
            settle();
        end

        // Strobe low with dir high: float and hold (R8).
        dir = 1'b1; wr_n = 1'b1; settle();
        wr_n = 1'b0; bus8_i = 4'hA; settle();
        check("R8 no drive", 32'(oe8), 0);
        check("R8 hold", 32'(sw8), 32'(exp_sw8(4'hF)));
        wr_n = 1'b1; settle();
        check("R8 readback unchanged", 32'(bus8_o), 32'hF);

        // Reset during readback, then during an open write (R5).
        rst_n = 1'b0; settle();
        check("R5 override readback oe", 32'(oe8), 0);
        check("R5 override sw", 32'(sw8), 0);
        dir = 1'b0; wr_n = 1'b0; bus8_i = 4'hF; bus4_i = 3'h7; settle();
        check("R5 override write sw8", 32'(sw8), 0);
        check("R5 override write sw4", 32'(sw4), 0);
        wr_n = 1'b1; settle();
        rst_n = 1'b1; dir = 1'b1; settle();
        check("R5 cleared readback8", 32'(bus8_o), 0);
        check("R5 cleared readback4", 32'(bus4_o), 0);
        dir = 1'b0; settle();

        // 4-channel sweep (R9).
        for (int v = 0; v < 8; v++) begin
            wr_n = 1'b0; bus4_i = 3'(v);
            settle();
            check("R9 transparent", 32'(sw4), 32'(exp_sw4(3'(v))));
            wr_n = 1'b1;
            settle();
            bus4_i = ~3'(v);
            settle();
            check("R9 hold", 32'(sw4), 32'(exp_sw4(3'(v))));
            dir = 1'b1;
            settle();
            check("R9 readback", 32'(bus4_o), 32'(v));
            check("R9 oe", 32'(oe4), 1);
            dir = 1'b0;
            settle();
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule